// File: doc/BRIEF.md
# Duty-Cycle Clock Throttle Generator

This block produces an active-low stop-clock request that places a processor in its stop-grant state for a programmable share of a fixed throttle period. The period lasts eight pulses of a slow tick enable. That enable is a one-cycle strobe at 32.768 kHz, so one period is about 244 µs. Within each period the request is held low for the first D ticks, where D is a 3-bit stopped-tick count.

Two sources can request throttling. The software mode has its own enable bit and duty count. The thermal mode is armed by a separate enable and fires while an active-low thermal alarm pin is low. That pin arrives asynchronously and passes through a synchronizer first. When both sources are active, the thermal duty count is used. Throttling also depends on a full-on indication from the power state controller. When the system leaves full-on, the request releases and the period restarts. When full-on returns, a fresh period begins on the next tick.

A duty count and a mode choice are sampled only on the first tick of each period. A change made in mid-period therefore never cuts a stop pulse short and never adds a stray one.

Top module: `throttle_gen`

## Requirements
- R1: While `full_on` is high, each `tick_en` pulse advances an internal slot index 0,1,…,7,0,…, so one throttle period spans eight ticks.
- R2: On the tick with slot index s, the stop request for that tick slot is asserted (`stpclk_n` = 0) exactly when s is less than the period's duty count D (0..7). The output takes that value in the clock cycle after the tick and holds it until the next tick. D = 0 never asserts the request.
- R3: With only software throttling active (`norm_en` = 1, thermal inactive), D is taken from `norm_duty`.
- R4: Thermal throttling is active while `therm_en` = 1 and the synchronized `therm_n` is 0. With only thermal active, D is taken from `therm_duty`. A change on `therm_n` is seen after two clock edges.
- R5: With both sources active, D is taken from `therm_duty`.
- R6: With neither source active, D is 0 and `stpclk_n` stays high.
- R7: While `full_on` is low, `stpclk_n` is high from the cycle after `full_on` falls, ticks are ignored, and the slot index returns to 0.
- R8: After `full_on` rises again, the next tick is slot 0 of a new period and samples a new D.
- R9: D and the mode choice are sampled only on the slot-0 tick. Changes to `norm_en`, `norm_duty`, `therm_en`, `therm_duty` or `therm_n` in mid-period do not affect the output until the next period.
- R10: After reset, `stpclk_n` is high and the next valid tick is slot 0.
- R11: `stpclk_n` changes only in the cycle after a tick taken in full-on, or in the cycle after `full_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| full_on | input | 1 | High while the system is in the full-on power state |
| norm_en | input | 1 | Software throttle enable |
| norm_duty | input | 3 | Software stopped-tick count per period |
| therm_en | input | 1 | Thermal throttle enable |
| therm_n | input | 1 | Asynchronous active-low thermal alarm |
| therm_duty | input | 3 | Thermal stopped-tick count per period |
| stpclk_n | output | 1 | Active-low stop-clock request |

## Verification
The assertions take for granted that `tick_en` is a single-cycle strobe from the same clock domain, and that `full_on` and the duty and enable inputs are synchronous to `clk`. Only `therm_n` may move freely. The stimulus drives every input on the falling clock edge and keeps ticks one cycle wide. It holds all settings, including the thermal pin, steady for at least three cycles before a tick, so the synchronizer delay never falls on a sampled tick. Random phases change settings in mid-period and toggle `full_on`, and each change is checked against a bench model of the period.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

    // Source that supplies the duty count for the current period
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_NORM  = 2'd1,
        MODE_THERM = 2'd2
    } thr_mode_e;

    localparam int unsigned THR_PHASE_W     = 3;
    localparam int unsigned THR_SYNC_STAGES = 2;

endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.chain[STAGES-1];

endmodule

// File: rtl/thr_duty_sel.sv
module thr_duty_sel
    import throttle_pkg::*;
#(
    parameter int unsigned DUTY_W = 3
) (
    input  logic              norm_en,
    input  logic [DUTY_W-1:0] norm_duty,
    input  logic              therm_act,
    input  logic [DUTY_W-1:0] therm_duty,
    output logic [DUTY_W-1:0] sel_duty
);

    thr_mode_e mode;

    // Thermal request outranks the software request
    always_comb begin
        if (therm_act) begin
            mode = MODE_THERM;
        end else if (norm_en) begin
            mode = MODE_NORM;
        end else begin
            mode = MODE_OFF;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_THERM: sel_duty = therm_duty;
            MODE_NORM:  sel_duty = norm_duty;
            default:    sel_duty = '0;
        endcase
    end

endmodule

// File: rtl/thr_period_ctr.sv
module thr_period_ctr #(
    parameter int unsigned PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               full_on,
    input  logic [PHASE_W-1:0] sel_duty,
    output logic               slot_tick,
    output logic [PHASE_W-1:0] slot,
    output logic [PHASE_W-1:0] duty_now
);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [PHASE_W-1:0] duty;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       boundary;

    always_comb begin
        st_d      = st_q;
        boundary  = (st_q.phase == '0);
        duty_now  = boundary ? sel_duty : st_q.duty;
        slot_tick = tick_en && full_on;
        slot      = st_q.phase;
        if (!full_on) begin
            st_d.phase = '0;
        end else if (tick_en) begin
            st_d.phase = st_q.phase + 1'b1;
            st_d.duty  = duty_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Each tick in full-on advances the slot index by one, wrapping
    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && full_on) |=> (st_q.phase == $past(st_q.phase) + 1'b1));

    // Leaving full-on returns the slot index to the start of a period
    p_phase_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_on |=> (st_q.phase == '0));

    // The latched duty only moves on a slot-0 tick
    p_duty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_en && full_on && st_q.phase == '0) |=> $stable(st_q.duty));

endmodule

// File: rtl/thr_stop_out.sv
module thr_stop_out #(
    parameter int unsigned PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               full_on,
    input  logic               slot_tick,
    input  logic [PHASE_W-1:0] slot,
    input  logic [PHASE_W-1:0] duty_now,
    output logic               stpclk_n
);

    typedef struct packed {
        logic stop;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!full_on) begin
            st_d.stop = 1'b0;
        end else if (slot_tick) begin
            st_d.stop = (slot < duty_now);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stpclk_n = ~st_q.stop;

    // Request released in the cycle after full-on is lost
    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_on |=> stpclk_n);

    // Between ticks the request holds its level
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full_on && !slot_tick) |=> $stable(stpclk_n));

    // A zero duty never produces a stop pulse
    p_zero_duty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && duty_now == '0) |=> stpclk_n);

    // Slot 0 with a nonzero duty always stops the clock
    p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && slot == '0 && duty_now != '0) |=> !stpclk_n);

endmodule

// File: rtl/throttle_gen.sv
module throttle_gen
    import throttle_pkg::*;
#(
    parameter int unsigned PHASE_W     = THR_PHASE_W,
    parameter int unsigned SYNC_STAGES = THR_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               full_on,
    input  logic               norm_en,
    input  logic [PHASE_W-1:0] norm_duty,
    input  logic               therm_en,
    input  logic               therm_n,
    input  logic [PHASE_W-1:0] therm_duty,
    output logic               stpclk_n
);

    logic               therm_n_sync;
    logic               therm_act;
    logic [PHASE_W-1:0] sel_duty;
    logic               slot_tick;
    logic [PHASE_W-1:0] slot;
    logic [PHASE_W-1:0] duty_now;

    thr_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_therm_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (therm_n),
        .sync_out (therm_n_sync)
    );

    assign therm_act = therm_en && !therm_n_sync;

    thr_duty_sel #(
        .DUTY_W (PHASE_W)
    ) u_duty_sel (
        .norm_en    (norm_en),
        .norm_duty  (norm_duty),
        .therm_act  (therm_act),
        .therm_duty (therm_duty),
        .sel_duty   (sel_duty)
    );

    thr_period_ctr #(
        .PHASE_W (PHASE_W)
    ) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .full_on   (full_on),
        .sel_duty  (sel_duty),
        .slot_tick (slot_tick),
        .slot      (slot),
        .duty_now  (duty_now)
    );

    thr_stop_out #(
        .PHASE_W (PHASE_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_on   (full_on),
        .slot_tick (slot_tick),
        .slot      (slot),
        .duty_now  (duty_now),
        .stpclk_n  (stpclk_n)
    );

    // With the thermal alarm in force, a slot-0 tick picks up the thermal count
    p_therm_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && slot == '0 && therm_act) |-> (duty_now == therm_duty));

    // Neither source active: slot-0 tick sees a zero duty
    p_no_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && slot == '0 && !therm_act && !norm_en) |-> (duty_now == '0));

endmodule

// File: tb/throttle_gen_tb.sv
module throttle_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       full_on = 1'b0;
    logic       norm_en = 1'b0;
    logic [2:0] norm_duty = 3'd0;
    logic       therm_en = 1'b0;
    logic       therm_n = 1'b1;
    logic [2:0] therm_duty = 3'd0;
    logic       stpclk_n;

    int checks = 0;
    int errors = 0;
    int m_phase = 0;
    int m_duty = 0;
    bit m_stop = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    throttle_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .full_on    (full_on),
        .norm_en    (norm_en),
        .norm_duty  (norm_duty),
        .therm_en   (therm_en),
        .therm_n    (therm_n),
        .therm_duty (therm_duty),
        .stpclk_n   (stpclk_n)
    );

    function automatic int pick_duty(bit ne, int nd, bit te, bit tn, int td);
        if (te && !tn) return td;
        if (ne) return nd;
        return 0;
    endfunction

    function automatic string pick_tag(bit ne, bit te, bit tn);
        if (te && !tn && ne) return "R5";
        if (te && !tn) return "R4";
        if (ne) return "R3";
        return "R6";
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: stpclk_n actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out(string tag);
        check(stpclk_n == !m_stop, tag, int'(stpclk_n), int'(!m_stop));
    endtask

    // Idle cycles: output must not move (R11)
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_out("R11");
        end
    endtask

    task automatic set_cfg(bit fo, bit ne, int nd, bit te, bit tn, int td);
        full_on    = fo;
        norm_en    = ne;
        norm_duty  = 3'(nd);
        therm_en   = te;
        therm_n    = tn;
        therm_duty = 3'(td);
        if (!fo) begin
            m_phase = 0;
            m_stop  = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check_out(fo ? "R11" : "R7");
        idle(2);
    endtask

    task automatic tick(string tag);
        string t;
        tick_en = 1'b1;
        if (full_on) begin
            if (m_phase == 0)
                m_duty = pick_duty(norm_en, norm_duty, therm_en, therm_n, therm_duty);
            m_stop  = (m_phase < m_duty);
            m_phase = (m_phase + 1) % 8;
        end
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        t = (tag == "") ? (full_on ? pick_tag(norm_en, therm_en, therm_n) : "R7") : tag;
        check_out(t);
    endtask

    task automatic run_ticks(int n, string tag);
        for (int i = 0; i < n; i++) begin
            tick(tag);
            idle(1 + ($urandom % 3));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(stpclk_n == 1'b1, "R10", int'(stpclk_n), 1);
        rst_n = 1'b1;
        idle(2);

        // Software throttle, duty 3, two periods (R1 R2 R3)
        set_cfg(1, 1, 3, 0, 1, 0);
        run_ticks(16, "");
        // Duty 0 never stops (R2)
        set_cfg(1, 1, 0, 0, 1, 0);
        run_ticks(8, "R2");
        run_ticks(8, "R2");
        // Duty 7 (R2)
        set_cfg(1, 1, 7, 0, 1, 0);
        run_ticks(16, "R2");
        // Thermal only (R4)
        set_cfg(1, 0, 5, 1, 0, 2);
        run_ticks(16, "R4");
        // Both sources: thermal count wins (R5)
        set_cfg(1, 1, 6, 1, 0, 1);
        run_ticks(16, "R5");
        // Thermal enabled but pin high: software count (R3)
        set_cfg(1, 1, 4, 1, 1, 7);
        run_ticks(8, "R3");
        // Neither source (R6)
        set_cfg(1, 0, 7, 0, 1, 7);
        run_ticks(8, "R6");
        // Mid-period change takes effect next period (R9)
        set_cfg(1, 1, 2, 0, 1, 0);
        run_ticks(3, "R9");
        set_cfg(1, 1, 6, 1, 0, 5);
        run_ticks(5, "R9");
        run_ticks(8, "R9");
        // Leave full-on mid-period; ticks ignored (R7)
        set_cfg(1, 1, 4, 0, 1, 0);
        run_ticks(2, "R7");
        set_cfg(0, 1, 4, 0, 1, 0);
        run_ticks(5, "R7");
        // Resume: fresh period from slot 0 (R8)
        set_cfg(1, 1, 4, 0, 1, 0);
        run_ticks(8, "R8");

        // Random phase
        for (int it = 0; it < 400; it++) begin
            if (($urandom % 6) == 0) begin
                set_cfg(($urandom % 5) != 0, $urandom % 2, $urandom % 8,
                        $urandom % 2, $urandom % 2, $urandom % 8);
            end
            run_ticks(1 + ($urandom % 4), "");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule